// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block decides whether a store-conditional may write memory when several hardware contexts share one memory. Each context can place a reservation on an address with a load-reserved request. Every write to the shared memory must also be presented to the monitor, whatever context issued it. Plain stores are always allowed. A store-conditional is allowed only when its own context still holds a live reservation on the same granule.

Addresses are reduced to a granule by dropping the low `GRAN_LSB` bits before they are stored or compared. The table has one slot per context. A slot holds a valid flag, the owning context ID and the granule address. Any presented write clears every slot whose granule equals the write's granule, whichever context owns the slot. The permit output is combinational in the cycle of the write, and the memory write enable is meant to be gated by it. Table updates take effect at the next rising clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation exists: a store-conditional presented before any load-reserved gets `wr_permit_o`=0 and `sc_pass_o`=0.
- R2: A load-reserved from context C followed by a store-conditional from C to the same address gives `wr_permit_o`=1 and `sc_pass_o`=1.
- R3: Addresses are compared at granule level, with granule = address >> GRAN_LSB. A store-conditional to another byte in the reserved granule succeeds. One to a different granule fails.
- R4: A store-conditional whose context ID differs from the reservation owner's fails, even when the granule matches.
- R5: Any presented write (plain or conditional, successful or not, any context) clears every reservation on its granule. A later store-conditional from those owners to that granule fails.
- R6: A plain store (`wr_cond_i`=0) always gets `wr_permit_o`=1 and `sc_valid_o`=0.
- R7: Each context holds at most one reservation. A second load-reserved from the same context replaces the stored granule, so a store-conditional to the old granule fails and one to the new granule succeeds.
- R8: A successful store-conditional consumes its reservation: an immediate repeat to the same granule fails.
- R9: When a load-reserved and a write arrive in the same cycle, the write is applied to the table first and the new reservation is installed after. This holds whether the write conflicts with the new granule or is a store-conditional from the same context.
- R10: `sc_valid_o` is 1 exactly for presented conditional writes. `sc_pass_o` is 1 only when `sc_valid_o` is 1 and the store-conditional succeeds, and it then equals `wr_permit_o`.
- R11: All NUM_CTX contexts can hold reservations at once on distinct granules. A write to one granule leaves reservations on other granules intact.
- R12: With `wr_valid_i`=0 the write fields are ignored: `wr_permit_o`=0, `sc_valid_o`=0, and no reservation is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all reservations |
| lr_valid_i | input | 1 | Load-reserved request present |
| lr_ctx_i | input | CTX_W | Context issuing the load-reserved |
| lr_addr_i | input | ADDR_W | Load-reserved byte address |
| wr_valid_i | input | 1 | Write present (every write to the shared memory) |
| wr_ctx_i | input | CTX_W | Context issuing the write |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_cond_i | input | 1 | 1 = store-conditional, 0 = plain store |
| wr_permit_o | output | 1 | Write may update memory (gates write enable) |
| sc_valid_o | output | 1 | Result of a store-conditional is being returned |
| sc_pass_o | output | 1 | Store-conditional result: 1 success, 0 failure |

## Verification
A load-reserved and a write can arrive in the same cycle, so the table must resolve a clear and an install on the same slot at once. The bench provokes this in two ways. A plain store from another context hits the granule being reserved. A store-conditional and a new load-reserved come from the same context on the same granule. In both cases a follow-up store-conditional in the next cycle must succeed, which shows the install took effect after the clear, and the same-cycle store-conditional must be judged against the table as it stood before the update.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_PLAIN = 2'd1,
    WR_COND  = 2'd2
  } wr_kind_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/llsc_entry.sv
module llsc_entry #(
  parameter int unsigned CTX_W  = 2,
  parameter int unsigned GRAN_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [CTX_W-1:0]  set_ctx_i,
  input  logic [GRAN_W-1:0] set_gran_i,
  output logic              vld_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [GRAN_W-1:0] gran_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      ctx_o  <= '0;
      gran_o <= '0;
    end else if (set_i) begin
      // install wins over a same-cycle clear
      vld_o  <= 1'b1;
      ctx_o  <= set_ctx_i;
      gran_o <= set_gran_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end

  // R5
  clear_kills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !vld_o);

  // R9
  install_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> vld_o && gran_o == $past(set_gran_i) && ctx_o == $past(set_ctx_i));

endmodule

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned CTX_W   = 2,
  parameter int unsigned GRAN_W  = 29
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CTX-1:0]             vld_i,
  input  logic [NUM_CTX-1:0][CTX_W-1:0]  ctx_i,
  input  logic [NUM_CTX-1:0][GRAN_W-1:0] gran_i,
  input  logic [CTX_W-1:0]               wr_ctx_i,
  input  logic [GRAN_W-1:0]              wr_gran_i,
  input  logic [CTX_W-1:0]               lr_ctx_i,
  output logic [NUM_CTX-1:0]             wr_gran_hit_o,
  output logic [NUM_CTX-1:0]             wr_own_hit_o,
  output logic [NUM_CTX-1:0]             lr_own_o
);

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_cmp
    logic gran_eq, wr_ctx_eq, lr_ctx_eq;
    assign gran_eq          = (gran_i[i] == wr_gran_i);
    assign wr_ctx_eq        = (ctx_i[i] == wr_ctx_i);
    assign lr_ctx_eq        = (ctx_i[i] == lr_ctx_i);
    assign wr_gran_hit_o[i] = vld_i[i] & gran_eq;
    assign wr_own_hit_o[i]  = vld_i[i] & gran_eq & wr_ctx_eq;
    assign lr_own_o[i]      = vld_i[i] & lr_ctx_eq;
  end

  // R7
  one_slot_per_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lr_own_o));

  // R7
  one_own_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_own_hit_o));

endmodule

// File: rtl/llsc_alloc.sv
module llsc_alloc #(
  parameter int unsigned NUM_CTX = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [NUM_CTX-1:0] vld_i,
  input  logic [NUM_CTX-1:0] own_i,
  output logic [NUM_CTX-1:0] sel_o
);

  logic [NUM_CTX-1:0] own_first, free_first;
  logic               own_any;

  always_comb begin
    own_first  = '0;
    free_first = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (own_i[i]) own_first  = NUM_CTX'(1) << i;
      if (!vld_i[i]) free_first = NUM_CTX'(1) << i;
    end
  end

  assign own_any = |own_i;
  // reuse the context's slot in place, else take the lowest free slot
  assign sel_o   = !req_i ? '0 : (own_any ? own_first : free_first);

  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R11
  slot_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> |sel_o);

  // R7
  reuse_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && own_any |-> (sel_o & own_i) != '0);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned NUM_CTX  = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_LSB = 3,
  localparam int unsigned CTX_W   = width_of(NUM_CTX),
  localparam int unsigned GRAN_W  = ADDR_W - GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_valid_i,
  input  logic [CTX_W-1:0]  lr_ctx_i,
  input  logic [ADDR_W-1:0] lr_addr_i,
  input  logic              wr_valid_i,
  input  logic [CTX_W-1:0]  wr_ctx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_cond_i,
  output logic              wr_permit_o,
  output logic              sc_valid_o,
  output logic              sc_pass_o
);

  logic [GRAN_W-1:0]              lr_gran, wr_gran;
  logic [NUM_CTX-1:0]             vld, gran_hit, own_hit, lr_own, sel;
  logic [NUM_CTX-1:0][CTX_W-1:0]  ent_ctx;
  logic [NUM_CTX-1:0][GRAN_W-1:0] ent_gran;
  wr_kind_e                       kind;
  logic                           sc_ok;

  assign lr_gran = lr_addr_i[ADDR_W-1:GRAN_LSB];
  assign wr_gran = wr_addr_i[ADDR_W-1:GRAN_LSB];

  always_comb begin
    if (!wr_valid_i)    kind = WR_NONE;
    else if (wr_cond_i) kind = WR_COND;
    else                kind = WR_PLAIN;
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
    llsc_entry #(.CTX_W(CTX_W), .GRAN_W(GRAN_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (sel[i]),
      .clr_i      ((kind != WR_NONE) && gran_hit[i]),
      .set_ctx_i  (lr_ctx_i),
      .set_gran_i (lr_gran),
      .vld_o      (vld[i]),
      .ctx_o      (ent_ctx[i]),
      .gran_o     (ent_gran[i])
    );
  end

  llsc_match #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .GRAN_W(GRAN_W)) u_match (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vld_i         (vld),
    .ctx_i         (ent_ctx),
    .gran_i        (ent_gran),
    .wr_ctx_i      (wr_ctx_i),
    .wr_gran_i     (wr_gran),
    .lr_ctx_i      (lr_ctx_i),
    .wr_gran_hit_o (gran_hit),
    .wr_own_hit_o  (own_hit),
    .lr_own_o      (lr_own)
  );

  llsc_alloc #(.NUM_CTX(NUM_CTX)) u_alloc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (lr_valid_i),
    .vld_i  (vld),
    .own_i  (lr_own),
    .sel_o  (sel)
  );

  assign sc_ok = |own_hit;

  always_comb begin
    unique case (kind)
      WR_PLAIN: wr_permit_o = 1'b1;
      WR_COND:  wr_permit_o = sc_ok;
      default:  wr_permit_o = 1'b0;
    endcase
  end

  assign sc_valid_o = (kind == WR_COND);
  assign sc_pass_o  = sc_valid_o & sc_ok;

  // R6
  plain_store_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_cond_i |-> wr_permit_o && !sc_valid_o);

  // R10
  pass_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_pass_o |-> sc_valid_o && wr_permit_o);

  // R12
  idle_no_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> !wr_permit_o && !sc_valid_o);

  // R1
  empty_sc_fails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld == '0 && sc_valid_o |-> !sc_pass_o);

  // R8
  consumed_after_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_pass_o && !lr_valid_i |=> (vld & ~$past(vld)) == '0 && $countones(vld) < $countones($past(vld)));

endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  localparam int unsigned NCTX = 4;
  localparam int unsigned AW   = 16;
  localparam int unsigned GL   = 3;
  localparam int unsigned CW   = 2;

  typedef struct packed {
    logic          lv;
    logic [CW-1:0] lc;
    logic [AW-1:0] la;
    logic          wv;
    logic [CW-1:0] wc;
    logic [AW-1:0] wa;
    logic          cond;
    logic          e_permit;
    logic          e_scv;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t mk(input logic lv, input int lc, input int la,
                              input logic wv, input int wc, input int wa,
                              input logic cond, input logic ep, input int rq);
    vec_t v;
    v.lv = lv; v.lc = CW'(lc); v.la = AW'(la);
    v.wv = wv; v.wc = CW'(wc); v.wa = AW'(wa);
    v.cond = cond; v.e_permit = ep; v.e_scv = wv & cond; v.req = 4'(rq);
    return v;
  endfunction

  localparam int NV = 36;
  // granule = 8 bytes; columns: lr(v,ctx,addr) wr(v,ctx,addr,cond) permit req
  localparam vec_t VECS [NV] = '{
    mk(0,0,'h000, 1,0,'h100,1, 0, 1),  // R1 no reservation yet
    mk(0,0,'h000, 1,1,'h200,0, 1, 6),  // R6 plain store
    mk(1,0,'h100, 0,0,'h000,0, 0, 2),  // R2 reserve
    mk(0,0,'h000, 1,0,'h104,1, 1, 3),  // R3 same granule other byte
    mk(0,0,'h000, 1,0,'h100,1, 0, 8),  // R8 consumed
    mk(1,1,'h200, 0,0,'h000,0, 0, 2),
    mk(0,0,'h000, 1,1,'h208,1, 0, 3),  // R3 other granule
    mk(0,0,'h000, 1,2,'h200,1, 0, 4),  // R4 wrong context, clears owner
    mk(0,0,'h000, 1,1,'h200,1, 0, 5),  // R5 killed by failed SC
    mk(1,2,'h300, 0,0,'h000,0, 0, 7),
    mk(1,2,'h310, 0,0,'h000,0, 0, 7),  // R7 replace
    mk(0,0,'h000, 1,2,'h300,1, 0, 7),  // R7 old granule
    mk(0,0,'h000, 1,2,'h310,1, 1, 7),  // R7 new granule
    mk(1,0,'h400, 0,0,'h000,0, 0, 5),
    mk(1,1,'h400, 0,0,'h000,0, 0, 5),
    mk(1,3,'h500, 0,0,'h000,0, 0, 11),
    mk(0,0,'h000, 1,3,'h402,0, 1, 5),  // R5 plain store kills two
    mk(0,0,'h000, 1,0,'h400,1, 0, 5),
    mk(0,0,'h000, 1,1,'h400,1, 0, 5),
    mk(0,0,'h000, 1,3,'h500,1, 1, 11), // R11 other granule intact
    mk(1,0,'h600, 1,2,'h600,0, 1, 9),  // R9 same-cycle conflict
    mk(0,0,'h000, 1,0,'h600,1, 1, 9),  // R9 reservation survived
    mk(1,1,'h700, 0,0,'h000,0, 0, 9),
    mk(1,1,'h700, 1,1,'h700,1, 1, 9),  // R9 SC judged on old table
    mk(0,0,'h000, 1,1,'h700,1, 1, 9),  // R9 re-reserved after
    mk(1,2,'h800, 0,0,'h000,0, 0, 12),
    mk(0,0,'h000, 0,3,'h800,0, 0, 12), // R12 idle write fields
    mk(0,0,'h000, 1,2,'h800,1, 1, 12), // R12 nothing cleared
    mk(1,0,'h900, 0,0,'h000,0, 0, 11),
    mk(1,1,'h910, 0,0,'h000,0, 0, 11),
    mk(1,2,'h920, 0,0,'h000,0, 0, 11),
    mk(1,3,'h930, 0,0,'h000,0, 0, 11), // R11 table full
    mk(0,0,'h000, 1,3,'h930,1, 1, 11),
    mk(0,0,'h000, 1,2,'h920,1, 1, 11),
    mk(0,0,'h000, 1,1,'h910,1, 1, 11),
    mk(0,0,'h000, 1,0,'h900,1, 1, 11)
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lr_valid_i = 1'b0, wr_valid_i = 1'b0, wr_cond_i = 1'b0;
  logic [CW-1:0] lr_ctx_i = '0, wr_ctx_i = '0;
  logic [AW-1:0] lr_addr_i = '0, wr_addr_i = '0;
  logic          wr_permit_o, sc_valid_o, sc_pass_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  llsc_monitor #(.NUM_CTX(NCTX), .ADDR_W(AW), .GRAN_LSB(GL)) u_llsc_monitor (
    .clk_i, .rst_ni, .lr_valid_i, .lr_ctx_i, .lr_addr_i,
    .wr_valid_i, .wr_ctx_i, .wr_addr_i, .wr_cond_i,
    .wr_permit_o, .sc_valid_o, .sc_pass_o
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s permit/scv/pass act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    lr_valid_i = v.lv; lr_ctx_i = v.lc; lr_addr_i = v.la;
    wr_valid_i = v.wv; wr_ctx_i = v.wc; wr_addr_i = v.wa; wr_cond_i = v.cond;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state, SC against an empty table
    #1;
    wr_valid_i = 1'b1; wr_cond_i = 1'b1; wr_addr_i = 16'h0100;
    #1;
    check("R1 in reset", {wr_permit_o, sc_valid_o, sc_pass_o}, 3'b010);
    wr_valid_i = 1'b0; wr_cond_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("vector %0d R%0d", i, VECS[i].req),
            {wr_permit_o, sc_valid_o, sc_pass_o},
            {VECS[i].e_permit, VECS[i].e_scv, VECS[i].e_permit & VECS[i].e_scv});
    end

    // R1 reset wipes a live reservation
    apply(mk(1,0,'hA00, 0,0,'h000,0, 0, 1));
    apply(mk(0,0,'h000, 0,0,'h000,0, 0, 1));
    rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    apply(mk(0,0,'h000, 1,0,'hA00,1, 0, 1));
    check("R1 after mid-run reset", {wr_permit_o, sc_valid_o, sc_pass_o}, 3'b010);

    // R10 plain store onto a reserved granule reports no SC result
    apply(mk(1,3,'hB00, 0,0,'h000,0, 0, 10));
    apply(mk(0,0,'h000, 1,3,'hB07,0, 1, 10));
    check("R10 plain on reserved", {wr_permit_o, sc_valid_o, sc_pass_o}, 3'b100);
    apply(mk(0,0,'h000, 1,3,'hB00,1, 0, 10));
    check("R5 plain store cleared own", {wr_permit_o, sc_valid_o, sc_pass_o}, 3'b010);

    // R2 upper granule boundary byte
    apply(mk(1,2,'hC08, 0,0,'h000,0, 0, 2));
    apply(mk(0,0,'h000, 1,2,'hC0F,1, 1, 2));
    check("R2 last byte of granule", {wr_permit_o, sc_valid_o, sc_pass_o}, 3'b111);

    apply(mk(0,0,'h000, 0,0,'h000,0, 0, 0));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule